// File: doc/BRIEF.md
# Shift-and-Saturate Unit

This block clamps a 32-bit register operand into a programmable signed or unsigned range and reports whether clamping took place through a sticky saturation flag. It has two operating forms. The word form can shift the operand by an immediate amount before clamping, either left (logical) or right (arithmetic). The dual-halfword form treats the operand as two independent 16-bit lanes and clamps each one separately.

An execute stage drives one operation per strobe. It supplies the decoded fields: opcode selects, saturation immediate, shift controls, the condition outcome and the two register indices. One cycle later the unit presents the result together with a write-enable pulse. An access that names the program-counter index produces a one-cycle "unpredictable" pulse instead of a write.

Top module: `sat_unit`

## Requirements
- R1: Word signed form (`op_signed`=1, `op_dual`=0) clamps the shifted value to a signed width of `sat_imm`+1 bits, covering the range -2^(`sat_imm`) .. 2^(`sat_imm`)-1. With `sat_imm`=31 it never clamps.
- R2: Word unsigned form (`op_signed`=0, `op_dual`=0) treats the shifted value as signed and clamps it to 0 .. 2^(`sat_imm`)-1. Negative values become 0, and `sat_imm`=0 always yields 0.
- R3: In the word form, the shift is applied before clamping. `shift_asr`=0 shifts left logically by `shift_amt`, dropping bits beyond bit 31. `shift_asr`=1 shifts right arithmetically by `shift_amt`, and an amount of 0 means a shift by 32, which gives all copies of bit 31.
- R4: Dual form (`op_dual`=1) ignores the shift controls and `sat_imm[4]`. It sign-extends bits 15:0 and bits 31:16 separately and clamps each half: signed to width `sat_imm[3:0]`+1, unsigned to width `sat_imm[3:0]`. The low-half result is packed into bits 15:0 and the high-half result into bits 31:16.
- R5: `q_flag` is set by a written operation that clamps in any way, including in either half. It stays set through later operations that do not clamp.
- R6: `q_clear` clears `q_flag` at the next edge. If the same edge also writes a clamping result, the flag ends up set.
- R7: When `in_valid` is high and `dst_idx` or `src_idx` equals 15, `unpred` pulses one cycle later. In that case `wr_en` stays low, `result` is unchanged and `q_flag` does not gain a set, whatever `cond_pass` is.
- R8: When `in_valid` is high and `cond_pass` is low (with legal indices), there is no write, `result` holds and `q_flag` does not gain a set.
- R9: A valid, passing operation drives `wr_en` high and presents `result` exactly one cycle after the strobe. `result` holds its last value whenever `wr_en` is low.
- R10: Synchronous reset drives `result`, `wr_en`, `unpred` and `q_flag` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation strobe |
| operand | input | 32 | Source register value |
| op_signed | input | 1 | 1 = signed clamp, 0 = unsigned clamp |
| op_dual | input | 1 | 1 = dual-halfword form, 0 = word form |
| sat_imm | input | 5 | Saturation immediate |
| shift_asr | input | 1 | Word form shift kind: 0 left logical, 1 right arithmetic |
| shift_amt | input | 5 | Word form shift amount |
| cond_pass | input | 1 | Condition outcome of the operation |
| dst_idx | input | 4 | Destination register index |
| src_idx | input | 4 | Source register index |
| q_clear | input | 1 | Clear the sticky flag |
| result | output | 32 | Clamped result |
| wr_en | output | 1 | Result write pulse |
| unpred | output | 1 | Program-counter index used |
| q_flag | output | 1 | Sticky saturation flag |

## Verification
The embedded properties assume that `rst` is held high for at least one edge before the first strobe. They also assume that every input is steady around each rising edge, with `q_clear` and `in_valid` treated as plain level inputs that may coincide. The stimulus drives all inputs on the falling edge and holds reset for several cycles. It mixes directed corner values (range edges, zero widths, shift by 32, both halves clamping, a clear that coincides with a clamping write) with a long run of random fields. In that run the register indices are biased toward 15 and `cond_pass` is sometimes low, so the blocking paths are exercised while staying inside those assumptions.

// File: rtl/sat_unit.sv
module sat_unit #(
  parameter int W      = 32,
  parameter int IDXW   = 4,
  parameter int PC_IDX = 15
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic [W-1:0]           operand,
  input  logic                   op_signed,
  input  logic                   op_dual,
  input  logic [$clog2(W)-1:0]   sat_imm,
  input  logic                   shift_asr,
  input  logic [$clog2(W)-1:0]   shift_amt,
  input  logic                   cond_pass,
  input  logic [IDXW-1:0]        dst_idx,
  input  logic [IDXW-1:0]        src_idx,
  input  logic                   q_clear,
  output logic [W-1:0]           result,
  output logic                   wr_en,
  output logic                   unpred,
  output logic                   q_flag
);
  localparam int SW = $clog2(W);
  localparam int HW = W / 2;

  // Returns {clamped, value}; x is signed, n is the target width.
  function automatic logic [W:0] clamp(input logic [W-1:0] x, input logic uns,
                                       input logic [SW:0] n);
    logic signed [W:0] xe, hi, lo, one;
    one = 1;
    xe  = $signed({x[W-1], x});
    if (uns) begin
      hi = (one <<< n) - one;
      lo = '0;
    end else begin
      hi = (one <<< (n - 1'b1)) - one;
      lo = -hi - one;
    end
    if (xe > hi)      clamp = {1'b1, hi[W-1:0]};
    else if (xe < lo) clamp = {1'b1, lo[W-1:0]};
    else              clamp = {1'b0, x};
  endfunction

  logic          idx_bad, fire;
  logic [W-1:0]  shifted;
  logic [SW:0]   n_word, n_half;
  logic [W:0]    c_word, c_lo, c_hi;
  logic [W-1:0]  nxt;
  logic          nxt_sat;

  assign idx_bad = (dst_idx == IDXW'(PC_IDX)) || (src_idx == IDXW'(PC_IDX));
  assign fire    = in_valid && !idx_bad && cond_pass;

  always_comb begin
    if (!shift_asr)             shifted = operand << shift_amt;
    else if (shift_amt == '0)   shifted = {W{operand[W-1]}};
    else                        shifted = W'($signed(operand) >>> shift_amt);
  end

  assign n_word = op_signed ? {1'b0, sat_imm} + 1'b1 : {1'b0, sat_imm};
  assign n_half = op_signed ? {2'b0, sat_imm[SW-2:0]} + 1'b1 : {2'b0, sat_imm[SW-2:0]};

  assign c_word = clamp(shifted, !op_signed, n_word);
  assign c_lo   = clamp({{HW{operand[HW-1]}}, operand[HW-1:0]}, !op_signed, n_half);
  assign c_hi   = clamp({{HW{operand[W-1]}}, operand[W-1:HW]}, !op_signed, n_half);

  assign nxt     = op_dual ? {c_hi[HW-1:0], c_lo[HW-1:0]} : c_word[W-1:0];
  assign nxt_sat = op_dual ? (c_lo[W] | c_hi[W]) : c_word[W];

  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
      wr_en  <= 1'b0;
      unpred <= 1'b0;
      q_flag <= 1'b0;
    end else begin
      wr_en  <= fire;
      unpred <= in_valid && idx_bad;
      if (fire) result <= nxt;
      q_flag <= (q_flag && !q_clear) || (fire && nxt_sat);
    end
  end

  p_unpred_no_write_r7: assert property (@(posedge clk) disable iff (rst)
    unpred |-> !wr_en);
  p_cond_low_no_write_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !cond_pass) |=> !wr_en);
  p_q_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    (q_flag && !q_clear) |=> q_flag);
  p_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (q_clear && !(in_valid && cond_pass)) |=> !q_flag);
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !wr_en |-> $stable(result));
  p_usat_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (fire && !op_signed && !op_dual && sat_imm == '0) |=> (result == '0));
endmodule

// File: tb/test_sat_unit.sv
`timescale 1ns/1ps
module test_sat_unit;
  logic clk = 0, rst = 1;
  logic in_valid = 0, op_signed = 0, op_dual = 0, shift_asr = 0, cond_pass = 0, q_clear = 0;
  logic [31:0] operand = 0;
  logic [4:0] sat_imm = 0, shift_amt = 0;
  logic [3:0] dst_idx = 0, src_idx = 0;
  logic [31:0] result;
  logic wr_en, unpred, q_flag;

  always #2.5 clk = ~clk;

  sat_unit i_sat_unit (.clk, .rst, .in_valid, .operand, .op_signed, .op_dual, .sat_imm,
    .shift_asr, .shift_amt, .cond_pass, .dst_idx, .src_idx, .q_clear,
    .result, .wr_en, .unpred, .q_flag);

  int checks = 0, fails = 0;
  bit done = 0, started = 0;
  string cur_tag = "R10", m_tag = "R10";
  bit [31:0] m_res; bit m_wr, m_un, m_q;

  function automatic longint ref_sat(longint x, bit uns, int n, inout bit s);
    longint hi, lo;
    if (uns) begin lo = 0; hi = (longint'(1) << n) - 1; end
    else begin hi = (longint'(1) << (n - 1)) - 1; lo = -hi - 1; end
    if (x > hi) begin s = 1; return hi; end
    if (x < lo) begin s = 1; return lo; end
    return x;
  endfunction

  always @(posedge clk) begin : model
    bit s; int v; longint a, b;
    started = 1;
    m_tag = cur_tag;
    if (rst) begin
      m_res = 0; m_wr = 0; m_un = 0; m_q = 0;
    end else begin
      s = 0; m_wr = 0; m_un = 0;
      if (in_valid) begin
        if (dst_idx == 15 || src_idx == 15) m_un = 1;
        else if (cond_pass) begin
          m_wr = 1;
          if (!op_dual) begin
            v = $signed(operand);
            if (!shift_asr) v = v << shift_amt;
            else if (shift_amt == 0) v = v >>> 31;
            else v = v >>> shift_amt;
            a = ref_sat(v, !op_signed, op_signed ? sat_imm + 1 : sat_imm, s);
            m_res = a[31:0];
          end else begin
            a = ref_sat(longint'($signed(operand[15:0])), !op_signed,
                        op_signed ? sat_imm[3:0] + 1 : sat_imm[3:0], s);
            b = ref_sat(longint'($signed(operand[31:16])), !op_signed,
                        op_signed ? sat_imm[3:0] + 1 : sat_imm[3:0], s);
            m_res = {b[15:0], a[15:0]};
          end
        end
      end
      m_q = (m_q && !q_clear) || (m_wr && s);
    end
  end

  task automatic chk(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) if (started && !done) begin
    chk(m_tag, "result", result, m_res);
    chk(m_tag, "wr_en", wr_en, m_wr);
    chk(m_tag, "unpred", unpred, m_un);
    chk(m_q != q_flag ? {m_tag, "/R5"} : m_tag, "q_flag", q_flag, m_q);
  end

  task automatic op(bit s, bit d, bit [4:0] imm, bit asr, bit [4:0] amt, bit cp,
                    bit [3:0] di, bit [3:0] si, bit [31:0] x, bit clr, string tag);
    in_valid = 1; op_signed = s; op_dual = d; sat_imm = imm; shift_asr = asr;
    shift_amt = amt; cond_pass = cp; dst_idx = di; src_idx = si; operand = x;
    q_clear = clr; cur_tag = tag;
    @(negedge clk);
    in_valid = 0; q_clear = 0;
  endtask

  task automatic expect_res(string tag, bit [31:0] exp);
    @(negedge clk);
    chk(tag, "directed result", result, exp);
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R10", "reset result", result, 0);
    chk("R10", "reset q_flag", q_flag, 0);
    rst = 0;
    @(negedge clk);
    op(1, 0, 7, 0, 0, 1, 1, 2, 300, 0, "R1");          expect_res("R1", 127);
    chk("R5", "q set", q_flag, 1);
    op(1, 0, 7, 0, 0, 1, 1, 2, -300, 0, "R1");         expect_res("R1", 32'hFFFF_FF80);
    op(1, 0, 31, 0, 0, 1, 1, 2, 32'h8000_0000, 0, "R1"); expect_res("R1", 32'h8000_0000);
    op(0, 0, 8, 0, 0, 1, 1, 2, 300, 1, "R6");          expect_res("R2", 255);
    chk("R6", "clear and set same edge", q_flag, 1);
    op(0, 0, 0, 0, 0, 1, 1, 2, 0, 1, "R6");            expect_res("R2", 0);
    chk("R6", "clear", q_flag, 0);
    op(0, 0, 8, 0, 0, 1, 1, 2, -5, 0, "R2");           expect_res("R2", 0);
    op(1, 0, 31, 0, 4, 1, 1, 2, 32'h1800_0001, 0, "R3"); expect_res("R3", 32'h8000_0010);
    op(1, 0, 31, 1, 0, 1, 1, 2, 32'h8000_1234, 0, "R3"); expect_res("R3", 32'hFFFF_FFFF);
    op(1, 0, 31, 1, 3, 1, 1, 2, 32'h0000_0100, 0, "R3"); expect_res("R3", 32'h20);
    op(1, 1, 5'h17, 1, 9, 1, 1, 2, 32'h7FFF_8000, 0, "R4"); expect_res("R4", 32'h007F_FF80);
    op(0, 1, 8, 0, 0, 1, 1, 2, 32'h0100_FFFF, 1, "R4"); expect_res("R4", 32'h00FF_0000);
    op(1, 0, 0, 0, 0, 1, 15, 2, 99, 0, "R7");         @(negedge clk);
    op(1, 0, 0, 0, 0, 0, 3, 15, 99, 0, "R7");         @(negedge clk);
    chk("R7", "unpred keeps result", result, 32'h00FF_0000);
    op(1, 0, 0, 0, 0, 0, 3, 4, 99, 0, "R8");          @(negedge clk);
    chk("R8", "cond fail keeps result", result, 32'h00FF_0000);
    chk("R9", "no write pulse", wr_en, 0);
    for (int i = 0; i < 4000; i++) begin
      bit [31:0] r = $urandom;
      bit [3:0] di = ($urandom % 8 == 0) ? 4'd15 : 4'($urandom);
      bit [3:0] si = ($urandom % 8 == 0) ? 4'd15 : 4'($urandom);
      op(r[0], r[1], 5'($urandom), r[2], 5'($urandom), ($urandom % 5) != 0, di, si,
         (r[3] ? $urandom : {r[31:28], 28'h0, r[7:4]}), ($urandom % 16) == 0,
         r[1] ? "R4" : (r[0] ? "R1" : "R2"));
      if (r[5]) @(negedge clk);
    end
    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule